// File: doc/BRIEF.md
# Bus Peripheral Protection Filter

This block sits on the path from a bus master to a row of peripheral windows. Each window is one fixed-size slice of the address space and has a peripheral ID. For every access the block looks up two attributes of the target peripheral. The first says whether the peripheral may only be reached by privileged code. The second says whether the peripheral is secure, which means it must be reached through the secure address alias. An access that breaks either rule is stopped before it reaches the peripheral. A stopped write is lost, and a stopped read hands the master a zero word.

Each violation raises its own fault flag: one flag for privilege, one for the alias. The block also latches the ID of the peripheral that was hit. A fault interrupt combines the flags with an enable mask. Software programs the attributes, a global protection enable, the interrupt enable, and set and clear masks for the flags. All of these sit in a small register window that the block serves by itself. That window is guarded by the same rules, under the block's own peripheral ID. Every access completes in the cycle it is presented, whether it is passed on or stopped, and no error response is ever raised.

Top module: `periph_guard`

## Requirements
- R1: Address decode. The peripheral ID is `m_addr[WIN_BITS +: ID_W]` (4 KB windows by default). `m_addr[SEC_BIT]` (bit 28 by default) set means the secure alias. The window whose ID equals `SELF_ID` (40 by default) is served by the block's own registers and is never forwarded. Any other permitted access is forwarded with the address left unchanged.
- R2: When protection is on, an unprivileged access (`m_priv`=0) to a peripheral whose privileged-only bit is set is blocked: `p_valid` stays low. A privileged access to that peripheral is not blocked.
- R3: A blocked read returns `m_rdata` = 0 in the same cycle. No error signal exists and no wait is added.
- R4: When protection is on, an access whose alias bit differs from the peripheral's secure bit is blocked. This covers a secure peripheral reached through the non-secure alias and a non-secure peripheral reached through the secure alias. Such an access sets flag bit 1 (alias fault).
- R5: A privilege violation sets flag bit 0 (privilege fault) on the clock edge that ends the access.
- R6: The fault-ID register loads the blocked peripheral's ID only when both flags are clear at the time of the fault. While any flag is set, the fault-ID register holds its value.
- R7: Peripheral n has its attribute bit in word n/32 at bit n%32. The privileged-only words are at register offsets 0x20 and 0x24. The secure words are at 0x40 and 0x44.
- R8: Writing a mask to offset 0x08 sets the flag bits that are 1 in the mask. Writing a mask to offset 0x0C clears them. Mask bits above bit 1 are ignored. Offset 0x04 reads the flags and offset 0x14 reads the fault ID.
- R9: `irq` is high when any flag bit is set and its enable bit is also set. The enable register is at offset 0x10. Writing the enable register leaves pending flags unchanged.
- R10: After reset: protection is on (offset 0x00 bit 0 = 1), all attribute bits are 0, and flags, enables and fault ID are all 0.
- R11: With offset 0x00 bit 0 cleared, no access is blocked and no flag is raised.
- R12: The block's own register window is checked under `SELF_ID`. A blocked register write leaves the register unchanged, and a blocked register read returns 0.
- R13: A permitted forwarded read returns `p_rdata` unchanged. A forwarded access drives `p_valid`, `p_write`, `p_addr` and `p_wdata` from the master in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master access present this cycle |
| m_write | input | 1 | 1 = write, 0 = read |
| m_priv | input | 1 | 1 = privileged master |
| m_addr | input | ADDR_W | Access address |
| m_wdata | input | DATA_W | Write data |
| m_rdata | output | DATA_W | Read data to master (0 when blocked) |
| p_valid | output | 1 | Forwarded access strobe toward the peripherals |
| p_write | output | 1 | Forwarded write flag |
| p_addr | output | ADDR_W | Forwarded address |
| p_wdata | output | DATA_W | Forwarded write data |
| p_rdata | input | DATA_W | Read data from the peripherals |
| irq | output | 1 | Fault interrupt |

## Verification
The bench locks down the block's own window by setting the block's own privileged-only bit. It then checks that an unprivileged write to the enable register has no effect. A design that exempted its own window would let that write switch protection off. A second fault is made to arrive while the first fault's flag is still set, and the fault ID must not move. A design that overwrote the ID would report the later peripheral. The bench sets a pending flag before writing the enable register and expects the interrupt to rise at once. A design that cleared pending flags when the enable was written would keep the interrupt low. The peripheral at ID 32 is used to confirm that the second attribute word is indexed from its own bit 0. An access through the secure alias with protection off confirms that the global enable gates both checks.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

  // Flag bit positions inside the fault flag register
  localparam int FLAG_PRIV = 0;
  localparam int FLAG_SEC  = 1;
  localparam int NFLAGS    = 2;

  // Word indices of the block's own registers (byte offset = 4 * index)
  localparam int RI_CTRL      = 0;
  localparam int RI_FLAGS     = 1;
  localparam int RI_FSET      = 2;
  localparam int RI_FCLR      = 3;
  localparam int RI_IEN       = 4;
  localparam int RI_FID       = 5;
  localparam int RI_PRIV_BASE = 8;
  localparam int RI_SEC_BASE  = 16;

endpackage

// File: rtl/pguard_decode.sv
module pguard_decode #(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 6,
  parameter int WIN_BITS = 12,
  parameter int SEC_BIT  = 28,
  parameter int SELF_ID  = 40,
  localparam int IDX_W   = WIN_BITS - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ID_W-1:0]   id,
  output logic              sec_alias,
  output logic              self_hit,
  output logic [IDX_W-1:0]  reg_idx
);

  function automatic logic [ID_W-1:0] window_of(input logic [ADDR_W-1:0] a);
    return a[WIN_BITS +: ID_W];
  endfunction

  function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[2 +: IDX_W];
  endfunction

  logic unused_addr;
  assign unused_addr = ^addr;

  assign id        = window_of(addr);
  assign sec_alias = addr[SEC_BIT];
  assign self_hit  = (window_of(addr) == ID_W'(SELF_ID));
  assign reg_idx   = word_of(addr);

endmodule

// File: rtl/pguard_check.sv
module pguard_check #(
  parameter int ID_W    = 6,
  localparam int NUM_PERIPH = 1 << ID_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid,
  input  logic                  priv,
  input  logic                  enable,
  input  logic [ID_W-1:0]       id,
  input  logic                  sec_alias,
  input  logic [NUM_PERIPH-1:0] priv_attr,
  input  logic [NUM_PERIPH-1:0] sec_attr,
  output logic                  priv_hit,
  output logic                  sec_hit,
  output logic                  deny
);

  function automatic logic attr_of(input logic [NUM_PERIPH-1:0] vec,
                                   input logic [ID_W-1:0] n);
    return vec[n];
  endfunction

  logic armed;
  assign armed    = valid & enable;
  assign priv_hit = armed & ~priv & attr_of(priv_attr, id);
  assign sec_hit  = armed & (sec_alias ^ attr_of(sec_attr, id));
  assign deny     = priv_hit | sec_hit;

  // R11: disabled protection never blocks
  p_off_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !deny);

  // R2: a privileged master never takes a privilege fault
  p_priv_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    priv |-> !priv_hit);

endmodule

// File: rtl/pguard_regs.sv
module pguard_regs
  import pguard_pkg::*;
#(
  parameter int ID_W     = 6,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12,
  localparam int NUM_PERIPH = 1 << ID_W,
  localparam int ATTR_WORDS = NUM_PERIPH / DATA_W,
  localparam int IDX_W      = WIN_BITS - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [DATA_W-1:0]     acc_wdata,
  input  logic                  priv_hit,
  input  logic                  sec_hit,
  input  logic [ID_W-1:0]       fault_id,
  output logic [DATA_W-1:0]     acc_rdata,
  output logic                  enable,
  output logic [NUM_PERIPH-1:0] priv_attr,
  output logic [NUM_PERIPH-1:0] sec_attr,
  output logic                  irq
);

  function automatic logic [NFLAGS-1:0] next_flags(input logic [NFLAGS-1:0] cur,
                                                   input logic [NFLAGS-1:0] set_m,
                                                   input logic [NFLAGS-1:0] clr_m,
                                                   input logic [NFLAGS-1:0] hw_m);
    return (cur & ~clr_m) | set_m | hw_m;
  endfunction

  logic                  enable_q;
  logic [NFLAGS-1:0]     flags_q;
  logic [NFLAGS-1:0]     ien_q;
  logic [ID_W-1:0]       fid_q;
  logic [DATA_W-1:0]     priv_w [ATTR_WORDS];
  logic [DATA_W-1:0]     sec_w  [ATTR_WORDS];

  logic                  wr;
  logic [NFLAGS-1:0]     set_m, clr_m, hw_m;
  logic                  capture;

  assign wr    = acc_valid & acc_write;
  assign set_m = (wr && acc_idx == IDX_W'(RI_FSET)) ? acc_wdata[NFLAGS-1:0] : '0;
  assign clr_m = (wr && acc_idx == IDX_W'(RI_FCLR)) ? acc_wdata[NFLAGS-1:0] : '0;

  always_comb begin
    hw_m            = '0;
    hw_m[FLAG_PRIV] = priv_hit;
    hw_m[FLAG_SEC]  = sec_hit;
  end

  assign capture = (|hw_m) && (flags_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b1;
      flags_q  <= '0;
      ien_q    <= '0;
      fid_q    <= '0;
    end else begin
      flags_q <= next_flags(flags_q, set_m, clr_m, hw_m);
      if (capture) fid_q <= fault_id;
      if (wr && acc_idx == IDX_W'(RI_CTRL)) enable_q <= acc_wdata[0];
      if (wr && acc_idx == IDX_W'(RI_IEN))  ien_q    <= acc_wdata[NFLAGS-1:0];
    end
  end

  for (genvar k = 0; k < ATTR_WORDS; k++) begin : g_attr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        priv_w[k] <= '0;
        sec_w[k]  <= '0;
      end else begin
        if (wr && acc_idx == IDX_W'(RI_PRIV_BASE + k)) priv_w[k] <= acc_wdata;
        if (wr && acc_idx == IDX_W'(RI_SEC_BASE + k))  sec_w[k]  <= acc_wdata;
      end
    end
    assign priv_attr[k*DATA_W +: DATA_W] = priv_w[k];
    assign sec_attr[k*DATA_W +: DATA_W]  = sec_w[k];
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      if (acc_idx == IDX_W'(RI_CTRL))  acc_rdata = DATA_W'(enable_q);
      if (acc_idx == IDX_W'(RI_FLAGS)) acc_rdata = DATA_W'(flags_q);
      if (acc_idx == IDX_W'(RI_IEN))   acc_rdata = DATA_W'(ien_q);
      if (acc_idx == IDX_W'(RI_FID))   acc_rdata = DATA_W'(fid_q);
      for (int k = 0; k < ATTR_WORDS; k++) begin
        if (acc_idx == IDX_W'(RI_PRIV_BASE + k)) acc_rdata = priv_w[k];
        if (acc_idx == IDX_W'(RI_SEC_BASE + k))  acc_rdata = sec_w[k];
      end
    end
  end

  assign enable = enable_q;
  assign irq    = |(flags_q & ien_q);

  p_priv_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    priv_hit |=> flags_q[FLAG_PRIV]);

  p_sec_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit |=> flags_q[FLAG_SEC]);

  p_fid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> $stable(fid_q));

  p_fid_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hw_m) && flags_q == '0) |=> fid_q == $past(fault_id));

  p_set_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_idx == IDX_W'(RI_FSET)) |=>
      (flags_q & $past(acc_wdata[NFLAGS-1:0])) == $past(acc_wdata[NFLAGS-1:0]));

  p_clr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_idx == IDX_W'(RI_FCLR) && !(priv_hit || sec_hit)) |=>
      (flags_q & $past(acc_wdata[NFLAGS-1:0])) == '0);

  p_ien_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_idx == IDX_W'(RI_IEN)) |=> flags_q == $past(flags_q));

endmodule

// File: rtl/periph_guard.sv
module periph_guard #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 6,
  parameter int WIN_BITS = 12,
  parameter int SEC_BIT  = 28,
  parameter int SELF_ID  = 40,
  localparam int NUM_PERIPH = 1 << ID_W,
  localparam int IDX_W      = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  input  logic              m_write,
  input  logic              m_priv,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic              p_valid,
  output logic              p_write,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_wdata,
  input  logic [DATA_W-1:0] p_rdata,
  output logic              irq
);

  logic [ID_W-1:0]       acc_id;
  logic                  acc_sec;
  logic                  self_hit;
  logic [IDX_W-1:0]      reg_idx;
  logic                  enable;
  logic [NUM_PERIPH-1:0] priv_attr, sec_attr;
  logic                  priv_hit, sec_hit, deny;
  logic                  fwd, local_acc;
  logic [DATA_W-1:0]     reg_rdata;

  pguard_decode #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .WIN_BITS(WIN_BITS),
    .SEC_BIT(SEC_BIT), .SELF_ID(SELF_ID)
  ) u_decode (
    .addr(m_addr), .id(acc_id), .sec_alias(acc_sec),
    .self_hit(self_hit), .reg_idx(reg_idx)
  );

  pguard_check #(.ID_W(ID_W)) u_check (
    .clk(clk), .rst_n(rst_n), .valid(m_valid), .priv(m_priv),
    .enable(enable), .id(acc_id), .sec_alias(acc_sec),
    .priv_attr(priv_attr), .sec_attr(sec_attr),
    .priv_hit(priv_hit), .sec_hit(sec_hit), .deny(deny)
  );

  assign local_acc = m_valid & self_hit & ~deny;
  assign fwd       = m_valid & ~self_hit & ~deny;

  pguard_regs #(.ID_W(ID_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(local_acc), .acc_write(m_write), .acc_idx(reg_idx),
    .acc_wdata(m_wdata), .priv_hit(priv_hit), .sec_hit(sec_hit),
    .fault_id(acc_id), .acc_rdata(reg_rdata), .enable(enable),
    .priv_attr(priv_attr), .sec_attr(sec_attr), .irq(irq)
  );

  assign p_valid = fwd;
  assign p_write = m_write;
  assign p_addr  = m_addr;
  assign p_wdata = m_wdata;

  always_comb begin
    m_rdata = '0;
    if (fwd && !m_write)       m_rdata = p_rdata;
    else if (local_acc)        m_rdata = reg_rdata;
  end

  p_block_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && deny) |-> !p_valid);

  p_zero_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && deny && !m_write) |-> m_rdata == '0);

  p_self_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
    self_hit |-> !p_valid);

  p_pass_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !m_write) |-> m_rdata == p_rdata);

endmodule

// File: tb/test_periph_guard.sv
module test_periph_guard;

  typedef struct packed {
    logic        wr;
    logic        priv;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        fwd;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  // Own register window of ID 40 at 0x0002_8000
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b0,1'b0,32'h0000_5010,32'h0,1'b1,32'hC0DE_5010,8'd13}, // R13 pass
    '{1'b1,1'b1,32'h0002_8020,32'h20,1'b0,32'h0,8'd7},         // R7 ID5 priv-only
    '{1'b1,1'b1,32'h0002_8024,32'h1,1'b0,32'h0,8'd7},          // R7 ID32 priv-only
    '{1'b0,1'b0,32'h0000_5010,32'h0,1'b0,32'h0,8'd3},          // R2 R3 blocked read
    '{1'b0,1'b1,32'h0002_8004,32'h0,1'b0,32'h1,8'd5},          // R5 flag
    '{1'b0,1'b1,32'h0002_8014,32'h0,1'b0,32'd5,8'd6},          // R6 id 5
    '{1'b1,1'b0,32'h0002_0000,32'h55,1'b0,32'h0,8'd7},         // R7 ID32 blocked
    '{1'b0,1'b1,32'h0002_8014,32'h0,1'b0,32'd5,8'd6},          // R6 id held
    '{1'b0,1'b1,32'h0000_5010,32'h0,1'b1,32'hC0DE_5010,8'd2},  // R2 priv ok
    '{1'b0,1'b0,32'h0000_4000,32'h0,1'b1,32'hC0DE_4000,8'd7},  // R7 ID4 open
    '{1'b1,1'b1,32'h0002_800C,32'h3,1'b0,32'h0,8'd8},          // R8 clear
    '{1'b0,1'b1,32'h0002_8004,32'h0,1'b0,32'h0,8'd8},
    '{1'b0,1'b1,32'h1000_7000,32'h0,1'b0,32'h0,8'd4},          // R4 sec alias, nonsec periph
    '{1'b0,1'b1,32'h0002_8004,32'h0,1'b0,32'h2,8'd4},
    '{1'b0,1'b1,32'h0002_8014,32'h0,1'b0,32'd7,8'd6},
    '{1'b1,1'b1,32'h0002_8040,32'h200,1'b0,32'h0,8'd4},        // ID9 secure
    '{1'b1,1'b1,32'h0002_800C,32'h3,1'b0,32'h0,8'd8},
    '{1'b0,1'b1,32'h0000_9000,32'h0,1'b0,32'h0,8'd4},          // R4 nonsec alias, sec periph
    '{1'b0,1'b1,32'h0002_8004,32'h0,1'b0,32'h2,8'd4},
    '{1'b0,1'b1,32'h0002_8014,32'h0,1'b0,32'd9,8'd6},
    '{1'b0,1'b1,32'h1000_9004,32'h0,1'b1,32'hC0DE_9004,8'd1},  // R1 secure alias ok
    '{1'b1,1'b1,32'h0002_800C,32'h3,1'b0,32'h0,8'd8},
    '{1'b1,1'b1,32'h0002_8024,32'h101,1'b0,32'h0,8'd12},       // R12 lock own window
    '{1'b0,1'b0,32'h0002_8000,32'h0,1'b0,32'h0,8'd12},
    '{1'b0,1'b1,32'h0002_8004,32'h0,1'b0,32'h1,8'd12},
    '{1'b0,1'b1,32'h0002_8014,32'h0,1'b0,32'd40,8'd12},
    '{1'b1,1'b0,32'h0002_8000,32'h0,1'b0,32'h0,8'd12},         // dropped write
    '{1'b0,1'b1,32'h0002_8000,32'h0,1'b0,32'h1,8'd12},
    '{1'b1,1'b1,32'h0002_8000,32'h0,1'b0,32'h0,8'd11},         // R11 disable
    '{1'b0,1'b0,32'h0000_5010,32'h0,1'b1,32'hC0DE_5010,8'd11},
    '{1'b0,1'b1,32'h1000_7000,32'h0,1'b1,32'hC0DE_7000,8'd11},
    '{1'b0,1'b0,32'h0002_8004,32'h0,1'b0,32'h1,8'd11},
    '{1'b1,1'b1,32'h0002_8000,32'h1,1'b0,32'h0,8'd11},
    '{1'b0,1'b0,32'h0002_8004,32'h0,1'b0,32'h0,8'd12},
    '{1'b1,1'b1,32'h0002_800C,32'h3,1'b0,32'h0,8'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_valid = 1'b0, m_write = 1'b0, m_priv = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [31:0] m_rdata, p_addr, p_wdata, p_rdata;
  logic        p_valid, p_write, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign p_rdata = {16'hC0DE, p_addr[15:0]};

  periph_guard i_periph_guard (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
    .m_priv(m_priv), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .p_valid(p_valid), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdata(p_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic pv, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_priv = pv; m_addr = a; m_wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    m_valid = 1'b0; m_write = 1'b0;
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    idle();
    check("R10 irq", {31'b0, irq}, 32'h0);
    bus(1'b0, 1'b1, 32'h0002_8000, 0); check("R10 ctrl", m_rdata, 32'h1);
    bus(1'b0, 1'b1, 32'h0002_8004, 0); check("R10 flags", m_rdata, 32'h0);
    bus(1'b0, 1'b1, 32'h0002_8010, 0); check("R10 ien", m_rdata, 32'h0);
    bus(1'b0, 1'b1, 32'h0002_8014, 0); check("R10 fid", m_rdata, 32'h0);
    bus(1'b0, 1'b1, 32'h0002_8024, 0); check("R10 priv1", m_rdata, 32'h0);
    bus(1'b0, 1'b1, 32'h0002_8044, 0); check("R10 sec1", m_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      bus(TBL[i].wr, TBL[i].priv, TBL[i].addr, TBL[i].wdata);
      check({tag, " fwd"}, {31'b0, p_valid}, {31'b0, TBL[i].fwd});
      if (!TBL[i].wr) check({tag, " rdata"}, m_rdata, TBL[i].rdata);
      if (TBL[i].fwd) check({tag, " addr"}, p_addr, TBL[i].addr);
    end

    // R8 set mask, R9 interrupt gating
    bus(1'b1, 1'b1, 32'h0002_8008, 32'h2);
    bus(1'b0, 1'b1, 32'h0002_8004, 0); check("R8 set", m_rdata, 32'h2);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    bus(1'b1, 1'b1, 32'h0002_8010, 32'h3);
    idle();
    check("R9 irq pending kept", {31'b0, irq}, 32'h1);
    bus(1'b0, 1'b1, 32'h0002_8004, 0); check("R9 flags kept", m_rdata, 32'h2);
    bus(1'b1, 1'b1, 32'h0002_800C, 32'h2);
    idle();
    check("R8 clear irq", {31'b0, irq}, 32'h0);
    bus(1'b1, 1'b1, 32'h0002_8008, 32'hFFFF_FFFC);
    bus(1'b0, 1'b1, 32'h0002_8004, 0); check("R8 high bits ignored", m_rdata, 32'h0);
    // R5 hardware fault raises interrupt with enable set
    bus(1'b1, 1'b0, 32'h0000_5000, 32'h77);
    check("R2 write blocked", {31'b0, p_valid}, 32'h0);
    idle();
    check("R5 irq from fault", {31'b0, irq}, 32'h1);

    idle();
    summary();
  end

endmodule